// File: doc/BRIEF.md
# Nine-Bit Multidrop UART Core

This block is a full-duplex asynchronous serial port. Each frame carries eight data bits, least significant first, and can carry one more bit. That ninth bit is either a parity bit worked out inside the core, or a software-supplied marker that tells address frames apart from data frames on a shared multidrop line. The transmitter and receiver have separate state machines and share only the bit-rate tick.

The bit rate comes from a tick at sixteen times the bit rate. In the variable-rate setting an external baud generator supplies this tick. In the fixed-rate setting the core divides the system clock itself, giving a bit time of 32 or 64 clock cycles.

The frame-done flags stay set until software clears them. In a multidrop slave the address filter is enabled, so only frames whose ninth bit is 1 reach software. Once a slave has recognised its own address, software turns the filter off to receive the data frames that follow.

Top module: `uart9_core`

## Requirements
- R1: The serial output idles at 1. A frame is a 0 start bit, then the eight data bits with bit 0 first, then the ninth bit if nine-bit mode is on, then the stop bits at 1. Each bit lasts 16 ticks.
- R2: With `two_stop` at 0 a frame ends after one stop bit; with `two_stop` at 1 it ends after two. `tx_done` rises about one bit time after the last stop bit starts, so a frame lasts 10, 11 or 12 bit times in total.
- R3: In nine-bit mode with parity off, the transmitted ninth bit equals `tx_bit9`. With parity on, the ninth bit is the XOR of the data bits when `parity_odd` is 0, and its inverse when `parity_odd` is 1.
- R4: An accepted nine-bit frame places its ninth bit on `rx_bit9`. An eight-bit frame gives `rx_bit9` = 0. `rx_par_err` is 1 only when parity and nine-bit mode are both on and the received ninth bit does not match the rule of R3.
- R5: With `addr_filt` and `nine_bit` both at 1, a frame whose ninth bit is 0 is dropped: `rx_done` stays 0 and `rx_data` keeps its old value. A frame whose ninth bit is 1 is accepted.
- R6: With `addr_filt` at 0, or in eight-bit mode, every well-formed frame is accepted, whatever its ninth bit.
- R7: `tx_done` and `rx_done` stay at 1 until a pulse on `tx_clr` or `rx_clr` clears them. `rx_clr` also clears `rx_overrun` and `rx_frame_err`.
- R8: With `fixed_rate` at 1, the bit time is 32 clock cycles when `fixed_div64` is 0 and 64 clock cycles when it is 1, and `ext_tick` is ignored.
- R9: A low pulse on the receive line that has ended by the middle of the start bit starts no frame and raises no flag.
- R10: A stop bit sampled low sets `rx_frame_err` and does not set `rx_done`.
- R11: A frame that completes while `rx_done` is still set raises `rx_overrun` and leaves `rx_data` unchanged.
- R12: A frame can be transmitted and another received at the same moment, and both arrive intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_tick | input | 1 | Oversampling tick from the external baud generator, 16 per bit |
| fixed_rate | input | 1 | 1: use the internal clock divider instead of `ext_tick` |
| fixed_div64 | input | 1 | Fixed-rate bit time: 0 gives 32 clocks, 1 gives 64 clocks |
| nine_bit | input | 1 | 1: frames carry a ninth bit |
| two_stop | input | 1 | 1: transmit two stop bits |
| parity_en | input | 1 | 1: ninth bit is parity |
| parity_odd | input | 1 | 1: odd parity, 0: even parity |
| addr_filt | input | 1 | 1: accept only frames whose ninth bit is 1 (nine-bit mode only) |
| tx_data | input | DW | Byte to send |
| tx_bit9 | input | 1 | Ninth bit to send when parity is off |
| tx_start | input | 1 | One-cycle request to send; taken only while idle |
| tx_clr | input | 1 | Clears `tx_done` |
| tx_busy | output | 1 | Transmitter is sending a frame |
| tx_done | output | 1 | Sticky frame-sent flag |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input (asynchronous) |
| rx_clr | input | 1 | Clears `rx_done`, `rx_overrun` and `rx_frame_err` |
| rx_data | output | DW | Last accepted byte |
| rx_bit9 | output | 1 | Ninth bit of the last accepted frame |
| rx_par_err | output | 1 | Parity mismatch in the last accepted frame |
| rx_done | output | 1 | Sticky frame-received flag |
| rx_overrun | output | 1 | A frame completed while `rx_done` was set |
| rx_frame_err | output | 1 | A stop bit was sampled low |

## Verification
Two situations are hard to reach from the ports. The first is the choice between a dropped data frame and an accepted address frame under the filter. The second is the interaction of that choice with parity and the overrun rule. The random receive loop reaches both by drawing the frame mode, parity sense, filter enable, data and sent ninth bit on every frame. For each frame the bench predicts acceptance and the parity flag, and it checks that a dropped frame leaves the previous byte in place.

A runt start pulse and a low stop bit are driven on purpose. The bench also runs a transmit and a receive at the same time, so the two state machines overlap while sharing one tick.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
  // frame phase shared by transmitter and receiver
  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_NINTH,
    S_STOP,
    S_WAIT
  } ph_t;
endpackage

// File: rtl/uart9_tickgen.sv
module uart9_tickgen #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_tick,
  input  logic fixed_rate,
  input  logic fixed_div64,
  output logic tick
);
  localparam int D32 = 32 / OSR;
  localparam int D64 = 64 / OSR;
  localparam int CW  = $clog2(D64) + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim = fixed_div64 ? CW'(D64 - 1) : CW'(D32 - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (!fixed_rate) begin
      cnt  <= '0;
      tick <= ext_tick;
    end else if (cnt >= lim) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // internal divider never produces back-to-back ticks
  AST_FIXED_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
    (fixed_rate && $past(fixed_rate) && tick) |=> !tick); // R8
endmodule

// File: rtl/uart9_tx.sv
module uart9_tx
  import uart9_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          start,
  input  logic [DW-1:0] data,
  input  logic          bit9_in,
  input  logic          nine_bit,
  input  logic          two_stop,
  input  logic          par_en,
  input  logic          par_odd,
  output logic          txd,
  output logic          busy,
  output logic          fin
);
  localparam int OW = $clog2(OSR);
  localparam int BW = $clog2(DW);

  ph_t           ph;
  logic [DW-1:0] sh;
  logic          b9, l_nine, l_two, stop2;
  logic [OW-1:0] ocnt;
  logic [BW-1:0] bcnt;
  logic          bit_end;

  assign bit_end = tick && (ocnt == OW'(OSR - 1));
  assign busy    = (ph != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= S_IDLE;
      sh     <= '0;
      b9     <= 1'b0;
      l_nine <= 1'b0;
      l_two  <= 1'b0;
      stop2  <= 1'b0;
      ocnt   <= '0;
      bcnt   <= '0;
      txd    <= 1'b1;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (ph == S_IDLE) begin
        if (start) begin
          sh     <= data;
          b9     <= par_en ? ((^data) ^ par_odd) : bit9_in;
          l_nine <= nine_bit;
          l_two  <= two_stop;
          ocnt   <= '0;
          ph     <= S_START;
          txd    <= 1'b0;
        end
      end else if (tick) begin
        ocnt <= ocnt + 1'b1;
        if (bit_end) begin
          ocnt <= '0;
          case (ph)
            S_START: begin
              ph   <= S_DATA;
              bcnt <= '0;
              txd  <= sh[0];
              sh   <= sh >> 1;
            end
            S_DATA: begin
              if (bcnt == BW'(DW - 1)) begin
                if (l_nine) begin
                  ph  <= S_NINTH;
                  txd <= b9;
                end else begin
                  ph    <= S_STOP;
                  txd   <= 1'b1;
                  stop2 <= 1'b0;
                end
              end else begin
                bcnt <= bcnt + 1'b1;
                txd  <= sh[0];
                sh   <= sh >> 1;
              end
            end
            S_NINTH: begin
              ph    <= S_STOP;
              txd   <= 1'b1;
              stop2 <= 1'b0;
            end
            S_STOP: begin
              if (l_two && !stop2) begin
                stop2 <= 1'b1;
              end else begin
                ph  <= S_IDLE;
                fin <= 1'b1;
              end
            end
            default: ph <= S_IDLE;
          endcase
        end
      end
    end
  end

  AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd); // R1
  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !txd); // R1
  AST_TX_FIN_IDLE: assert property (@(posedge clk) disable iff (rst)
    fin |-> (!busy && txd)); // R2
endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
  import uart9_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rxd_s,
  input  logic          nine_bit,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          filt,
  output logic          valid,
  output logic          ferr,
  output logic [DW-1:0] data,
  output logic          bit9,
  output logic          perr
);
  localparam int OW   = $clog2(OSR);
  localparam int BW   = $clog2(DW);
  localparam int HALF = OSR / 2;

  ph_t           ph;
  logic [OW-1:0] ocnt;
  logic [BW-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= S_IDLE;
      ocnt  <= '0;
      bcnt  <= '0;
      data  <= '0;
      bit9  <= 1'b0;
      perr  <= 1'b0;
      valid <= 1'b0;
      ferr  <= 1'b0;
    end else begin
      valid <= 1'b0;
      ferr  <= 1'b0;
      case (ph)
        S_IDLE: begin
          if (tick && !rxd_s) begin
            ph   <= S_START;
            ocnt <= '0;
          end
        end
        S_START: begin
          if (tick) begin
            if (ocnt == OW'(HALF - 1)) begin
              ocnt <= '0;
              if (rxd_s) begin
                ph <= S_IDLE;
              end else begin
                ph   <= S_DATA;
                bcnt <= '0;
                bit9 <= 1'b0;
              end
            end else begin
              ocnt <= ocnt + 1'b1;
            end
          end
        end
        S_DATA, S_NINTH, S_STOP: begin
          if (tick) begin
            if (ocnt == OW'(OSR - 1)) begin
              ocnt <= '0;
              if (ph == S_DATA) begin
                data <= {rxd_s, data[DW-1:1]};
                if (bcnt == BW'(DW - 1)) ph <= nine_bit ? S_NINTH : S_STOP;
                else bcnt <= bcnt + 1'b1;
              end else if (ph == S_NINTH) begin
                bit9 <= rxd_s;
                ph   <= S_STOP;
              end else if (!rxd_s) begin
                ferr <= 1'b1;
                ph   <= S_WAIT;
              end else begin
                ph    <= S_IDLE;
                perr  <= par_en && nine_bit && (bit9 != ((^data) ^ par_odd));
                valid <= !(filt && nine_bit && !bit9);
              end
            end else begin
              ocnt <= ocnt + 1'b1;
            end
          end
        end
        S_WAIT: if (rxd_s) ph <= S_IDLE;
        default: ph <= S_IDLE;
      endcase
    end
  end

  AST_RX_OK_XOR_BAD: assert property (@(posedge clk) disable iff (rst)
    !(valid && ferr)); // R10
  AST_RX_FILTER_GATE: assert property (@(posedge clk) disable iff (rst)
    valid |-> !($past(filt) && $past(nine_bit) && !bit9)); // R5
endmodule

// File: rtl/uart9_core.sv
module uart9_core #(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ext_tick,
  input  logic          fixed_rate,
  input  logic          fixed_div64,
  input  logic          nine_bit,
  input  logic          two_stop,
  input  logic          parity_en,
  input  logic          parity_odd,
  input  logic          addr_filt,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_bit9,
  input  logic          tx_start,
  input  logic          tx_clr,
  output logic          tx_busy,
  output logic          tx_done,
  output logic          txd,
  input  logic          rxd,
  input  logic          rx_clr,
  output logic [DW-1:0] rx_data,
  output logic          rx_bit9,
  output logic          rx_par_err,
  output logic          rx_done,
  output logic          rx_overrun,
  output logic          rx_frame_err
);
  logic          tick;
  logic [1:0]    rx_sync;
  logic          tx_fin;
  logic          rx_ok, rx_bad, rx_b9, rx_pe;
  logic [DW-1:0] rx_sh;

  uart9_tickgen #(.OSR(OSR)) u_tick (
    .clk(clk), .rst(rst), .ext_tick(ext_tick), .fixed_rate(fixed_rate),
    .fixed_div64(fixed_div64), .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (rst) rx_sync <= 2'b11;
    else     rx_sync <= {rx_sync[0], rxd};
  end

  uart9_tx #(.DW(DW), .OSR(OSR)) u_tx (
    .clk(clk), .rst(rst), .tick(tick), .start(tx_start), .data(tx_data),
    .bit9_in(tx_bit9), .nine_bit(nine_bit), .two_stop(two_stop),
    .par_en(parity_en), .par_odd(parity_odd), .txd(txd), .busy(tx_busy),
    .fin(tx_fin)
  );

  uart9_rx #(.DW(DW), .OSR(OSR)) u_rx (
    .clk(clk), .rst(rst), .tick(tick), .rxd_s(rx_sync[1]), .nine_bit(nine_bit),
    .par_en(parity_en), .par_odd(parity_odd), .filt(addr_filt),
    .valid(rx_ok), .ferr(rx_bad), .data(rx_sh), .bit9(rx_b9), .perr(rx_pe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_done      <= 1'b0;
      rx_done      <= 1'b0;
      rx_overrun   <= 1'b0;
      rx_frame_err <= 1'b0;
      rx_data      <= '0;
      rx_bit9      <= 1'b0;
      rx_par_err   <= 1'b0;
    end else begin
      if (tx_fin)      tx_done <= 1'b1;
      else if (tx_clr) tx_done <= 1'b0;

      if (rx_bad)      rx_frame_err <= 1'b1;
      else if (rx_clr) rx_frame_err <= 1'b0;

      if (rx_ok) begin
        if (rx_done && !rx_clr) begin
          rx_overrun <= 1'b1;
        end else begin
          rx_data    <= rx_sh;
          rx_bit9    <= rx_b9;
          rx_par_err <= rx_pe;
          rx_done    <= 1'b1;
          if (rx_clr) rx_overrun <= 1'b0;
        end
      end else if (rx_clr) begin
        rx_done    <= 1'b0;
        rx_overrun <= 1'b0;
      end
    end
  end

  AST_TXDONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (tx_done && !tx_clr) |=> tx_done); // R7
  AST_RXDONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (rx_done && !rx_clr) |=> rx_done); // R7
  AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (rx_done && !rx_clr) |=> $stable(rx_data)); // R11
endmodule

// File: tb/uart9_core_bench.sv
module uart9_core_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext_tick = 1'b0;
  logic       fixed_rate = 1'b0, fixed_div64 = 1'b0;
  logic       nine_bit = 1'b0, two_stop = 1'b0, parity_en = 1'b0, parity_odd = 1'b0;
  logic       addr_filt = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_bit9 = 1'b0, tx_start = 1'b0, tx_clr = 1'b0;
  logic       tx_busy, tx_done, txd;
  logic       rxd = 1'b1, rx_clr = 1'b0;
  logic [7:0] rx_data;
  logic       rx_bit9, rx_par_err, rx_done, rx_overrun, rx_frame_err;

  int checks = 0;
  int errors = 0;
  bit ended = 1'b0;

  uart9_core u_uart9_core (
    .clk(clk), .rst(rst), .ext_tick(ext_tick), .fixed_rate(fixed_rate),
    .fixed_div64(fixed_div64), .nine_bit(nine_bit), .two_stop(two_stop),
    .parity_en(parity_en), .parity_odd(parity_odd), .addr_filt(addr_filt),
    .tx_data(tx_data), .tx_bit9(tx_bit9), .tx_start(tx_start), .tx_clr(tx_clr),
    .tx_busy(tx_busy), .tx_done(tx_done), .txd(txd), .rxd(rxd), .rx_clr(rx_clr),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_par_err(rx_par_err),
    .rx_done(rx_done), .rx_overrun(rx_overrun), .rx_frame_err(rx_frame_err)
  );

  always #10 clk = ~clk;

  // external baud generator: one tick every 4 clocks -> 64-clock bits
  initial begin
    forever begin
      repeat (3) @(posedge clk);
      #1 ext_tick = 1'b1;
      @(posedge clk);
      #1 ext_tick = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic ninth_of(input logic [7:0] d, input logic b9, input logic pe, input logic po);
    return pe ? ((^d) ^ po) : b9;
  endfunction

  function automatic logic [11:0] frame_of(input logic [7:0] d, input logic n9, input logic nine, input logic two);
    logic [11:0] f;
    f = '0;
    f[8:1] = d;
    if (nine) begin
      f[9] = n9; f[10] = 1'b1; if (two) f[11] = 1'b1;
    end else begin
      f[9] = 1'b1; if (two) f[10] = 1'b1;
    end
    return f;
  endfunction

  task automatic pulse_clr();
    @(posedge clk); #1 tx_clr = 1'b1; rx_clr = 1'b1;
    @(posedge clk); #1 tx_clr = 1'b0; rx_clr = 1'b0;
  endtask

  task automatic hold(input logic v, input int bc);
    #1 rxd = v;
    repeat (bc) @(posedge clk);
  endtask

  task automatic drive_frame(input logic [7:0] d, input logic b9, input logic nine,
                             input logic stop_ok, input int bc);
    @(posedge clk);
    hold(1'b0, bc);
    for (int i = 0; i < 8; i++) hold(d[i], bc);
    if (nine) hold(b9, bc);
    hold(stop_ok, bc);
    hold(1'b1, 2 * bc);
  endtask

  task automatic kick_tx(input logic [7:0] d, input logic b9);
    @(posedge clk); #1 tx_data = d; tx_bit9 = b9; tx_start = 1'b1;
    @(posedge clk); #1 tx_start = 1'b0;
  endtask

  task automatic grab_tx(input int bc, input int nbits, output logic [11:0] bits, output int dur);
    int c;
    bits = '0;
    @(negedge clk);
    c = 0;
    while (txd !== 1'b0 && c < 2000) begin @(negedge clk); c++; end
    c = 0;
    while (tx_done !== 1'b1 && c < 16 * bc) begin
      for (int i = 0; i < nbits; i++) if (c == bc / 2 + i * bc) bits[i] = txd;
      @(negedge clk);
      c++;
    end
    dur = c;
  endtask

  logic [11:0] got, exp_f;
  int          dur, len;
  logic [7:0]  d, prev;
  logic        b9, n9, acc, pe_exp;

  task automatic tx_case(input int bc, input string tag);
    n9    = ninth_of(d, b9, parity_en & nine_bit, parity_odd);
    len   = 10 + int'(nine_bit) + int'(two_stop);
    exp_f = frame_of(d, n9, nine_bit, two_stop);
    kick_tx(d, b9);
    grab_tx(bc, len, got, dur);
    chk(got == exp_f, tag, 32'(got), 32'(exp_f));
    chk(dur >= len * bc - 4 && dur <= len * bc + 2, "R2 frame length", 32'(dur), 32'(len * bc));
    pulse_clr();
  endtask

  initial begin
    void'($urandom(32'd7351));
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R1 idle line", 32'(txd), 32'd1);
    chk({tx_busy, tx_done, rx_done, rx_overrun, rx_frame_err} == 5'b0, "R7 reset flags",
        32'({tx_busy, tx_done, rx_done, rx_overrun, rx_frame_err}), 32'd0);

    // directed: 8-bit, one stop, and a 9-bit marker frame
    nine_bit = 1'b0; two_stop = 1'b0; d = 8'hA5; b9 = 1'b0;
    tx_case(64, "R1 8-bit frame");
    nine_bit = 1'b1; d = 8'h3C; b9 = 1'b1;
    tx_case(64, "R3 marker bit");

    // random transmit frames
    for (int k = 0; k < 14; k++) begin
      nine_bit = 1'($urandom); two_stop = 1'($urandom);
      parity_en = 1'($urandom); parity_odd = 1'($urandom);
      d = 8'($urandom); b9 = 1'($urandom);
      tx_case(64, nine_bit ? "R3 ninth bit" : "R1 frame bits");
    end
    parity_en = 1'b0;

    // R7: tx_done held until cleared
    nine_bit = 1'b0; two_stop = 1'b0;
    kick_tx(8'h11, 1'b0);
    grab_tx(64, 10, got, dur);
    repeat (300) @(posedge clk);
    @(negedge clk);
    chk(tx_done == 1'b1, "R7 tx_done holds", 32'(tx_done), 32'd1);
    pulse_clr();
    @(negedge clk);
    chk(tx_done == 1'b0, "R7 tx_done clears", 32'(tx_done), 32'd0);

    // random receive frames: modes, parity, filter
    prev = rx_data;
    for (int k = 0; k < 24; k++) begin
      nine_bit = 1'($urandom); parity_en = nine_bit & 1'($urandom);
      parity_odd = 1'($urandom); addr_filt = 1'($urandom);
      d = 8'($urandom); b9 = 1'($urandom);
      acc    = !(addr_filt && nine_bit && !b9);
      pe_exp = parity_en && nine_bit && (b9 != ((^d) ^ parity_odd));
      drive_frame(d, b9, nine_bit, 1'b1, 64);
      @(negedge clk);
      if (acc) begin
        chk(rx_done == 1'b1, addr_filt ? "R5 address accepted" : "R6 frame accepted", 32'(rx_done), 32'd1);
        chk(rx_data == d, "R6 rx data", 32'(rx_data), 32'(d));
        chk(rx_bit9 == (nine_bit & b9), "R4 rx ninth bit", 32'(rx_bit9), 32'(nine_bit & b9));
        chk(rx_par_err == pe_exp, "R4 parity flag", 32'(rx_par_err), 32'(pe_exp));
        prev = d;
      end else begin
        chk(rx_done == 1'b0, "R5 data frame dropped", 32'(rx_done), 32'd0);
        chk(rx_data == prev, "R5 data kept", 32'(rx_data), 32'(prev));
      end
      pulse_clr();
    end
    addr_filt = 1'b0; parity_en = 1'b0; nine_bit = 1'b0;

    // R7: rx_done sticky
    drive_frame(8'h5A, 1'b0, 1'b0, 1'b1, 64);
    repeat (300) @(posedge clk);
    @(negedge clk);
    chk(rx_done == 1'b1, "R7 rx_done holds", 32'(rx_done), 32'd1);
    // R11: second frame while flag set
    drive_frame(8'hC3, 1'b0, 1'b0, 1'b1, 64);
    @(negedge clk);
    chk(rx_overrun == 1'b1, "R11 overrun set", 32'(rx_overrun), 32'd1);
    chk(rx_data == 8'h5A, "R11 old byte kept", 32'(rx_data), 32'h5A);
    pulse_clr();
    @(negedge clk);
    chk({rx_done, rx_overrun} == 2'b00, "R7 rx flags clear", 32'({rx_done, rx_overrun}), 32'd0);

    // R9: runt start pulse (12 clocks, 3 ticks)
    @(posedge clk);
    hold(1'b0, 12);
    hold(1'b1, 256);
    @(negedge clk);
    chk({rx_done, rx_frame_err} == 2'b00, "R9 runt start ignored", 32'({rx_done, rx_frame_err}), 32'd0);

    // R10: low stop bit
    drive_frame(8'h77, 1'b0, 1'b0, 1'b0, 64);
    @(negedge clk);
    chk(rx_frame_err == 1'b1, "R10 framing error", 32'(rx_frame_err), 32'd1);
    chk(rx_done == 1'b0, "R10 no receive event", 32'(rx_done), 32'd0);
    pulse_clr();
    @(negedge clk);
    chk(rx_frame_err == 1'b0, "R7 framing flag clears", 32'(rx_frame_err), 32'd0);

    // R12: simultaneous transmit and receive
    nine_bit = 1'b1; two_stop = 1'b0; d = 8'h96; b9 = 1'b1;
    exp_f = frame_of(d, 1'b1, 1'b1, 1'b0);
    fork
      begin kick_tx(d, b9); grab_tx(64, 11, got, dur); end
      drive_frame(8'h2D, 1'b0, 1'b1, 1'b1, 64);
    join
    @(negedge clk);
    chk(got == exp_f, "R12 tx during rx", 32'(got), 32'(exp_f));
    chk(rx_done == 1'b1 && rx_data == 8'h2D, "R12 rx during tx", 32'(rx_data), 32'h2D);
    pulse_clr();

    // R8: fixed rates, external tick ignored
    fixed_rate = 1'b1; fixed_div64 = 1'b0; nine_bit = 1'b0;
    d = 8'h4E; b9 = 1'b0;
    tx_case(32, "R8 fixed 32 tx");
    drive_frame(8'hB1, 1'b0, 1'b0, 1'b1, 32);
    @(negedge clk);
    chk(rx_done == 1'b1 && rx_data == 8'hB1, "R8 fixed 32 rx", 32'(rx_data), 32'hB1);
    pulse_clr();
    fixed_div64 = 1'b1; d = 8'hE7;
    tx_case(64, "R8 fixed 64 tx");
    fixed_rate = 1'b0;

    if (!ended) begin
      ended = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule